// File: doc/BRIEF.md
# Serial Receive Word Assembler

This block sits behind a bit-level receive front end and turns its qualified serial stream into 16-bit words for a downstream receive buffer. The front end supplies a one-cycle bit strobe in the system clock domain, the data bit that goes with it, a carrier-present level and a one-cycle preamble-seen pulse. Preamble detection, line decoding, the buffer and host access all live outside this block.

A preamble pulse arms the receiver while it is idle. The first bit strobe after arming that arrives with carrier present moves the block into its packet mode, and that strobe's bit is the first data bit. Bits are gathered most significant first, so the first byte of each word ends up as the high byte. Each completed word is presented with an odd-parity 17th bit and a one-cycle write strobe. When carrier is absent at a bit strobe, the packet ends. If the packet did not end on a word boundary, a sticky alignment-error flag is raised. If exactly one byte of the word had arrived, that byte is still written as a partial word.

Top module: `rxw_assembler`

## Requirements
- R1: After synchronous reset, packet mode is off, the bit count is 0, the alignment flag is 0 and the write strobe is 0.
- R2: Bit strobes with carrier present do not start packet mode unless a preamble pulse has armed the block since the last packet ended.
- R3: When the block is armed, a bit strobe with carrier present enters packet mode and takes that strobe's bit as the first data bit, so the bit count reads 1 afterwards.
- R4: Bits are assembled most significant first; the first eight bits of a word form its high byte (word bits 15..8).
- R5: The strobe carrying the 16th bit of a word raises the write strobe for exactly one cycle. In the cycle after that strobe, the complete word is on the data output and the bit count is back to 0.
- R6: The parity output makes the XOR of the 16 data bits and the parity bit equal to 1 (odd parity) whenever the write strobe is high.
- R7: A bit strobe with carrier absent during packet mode leaves packet mode and returns the bit count to 0.
- R8: A packet that ends with bit count 0 leaves the alignment flag at 0 and produces no write.
- R9: A packet that ends with bit count 8 sets the alignment flag and writes a partial word with the received byte in bits 15..8 and zeros in bits 7..0.
- R10: A packet that ends with any other nonzero bit count sets the alignment flag and produces no write.
- R11: The alignment flag holds until a preamble pulse arrives while idle, and that pulse clears it.
- R12: In cycles without a bit strobe, the bit count and packet mode do not change, whatever the data and carrier inputs do.
- R13: A preamble pulse during packet mode has no effect on packet mode or the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe marking a valid received bit |
| bit_in | input | 1 | Received data bit, valid with bit_tick |
| carrier | input | 1 | Carrier present level, sampled with bit_tick |
| preamble_seen | input | 1 | One-cycle pulse from the preamble detector |
| pkt_active | output | 1 | Packet mode is on |
| bit_cnt | output | 4 | Number of bits of the current word received so far |
| word_data | output | 16 | Last assembled word |
| word_par | output | 1 | Odd parity bit for word_data |
| word_wr | output | 1 | One-cycle write strobe for word_data |
| bad_align | output | 1 | Sticky flag: last packet ended off a word boundary |

## Verification
A wrong bit count shows up at the very next word boundary. The write strobe lands on the wrong strobe, or the word comes out rotated, and bit_cnt at the port disagrees with the number of strobes sent. A wrong mode state shows within one bit strobe, because packet mode either starts without arming or does not end on carrier loss. The sweep ends packets at every bit position in a word, so an error in the end-of-packet decision shows up at once on bad_align or as an unexpected or missing write.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_PKT  = 1'b1
    } rx_mode_e;

    function automatic logic odd_fill(input logic [15:0] w);
        return ~(^w);
    endfunction

endpackage

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
    import rxw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             carrier,
    input  logic             preamble_seen,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic             bad,
    output logic             shift_en,
    output logic             word_last,
    output logic             part_wr
);

    typedef struct packed {
        rx_mode_e         mode;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             bad;
    } ctrl_t;

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HALF_POS = CNT_W'(BYTE_W);

    ctrl_t st_d, st_q;
    logic  enter;

    always_comb begin
        st_d      = st_q;
        shift_en  = 1'b0;
        word_last = 1'b0;
        part_wr   = 1'b0;
        enter     = 1'b0;
        if (bit_tick) begin
            if (st_q.mode == MODE_PKT) begin
                if (carrier) begin
                    shift_en  = 1'b1;
                    word_last = (st_q.cnt == LAST_POS);
                    st_d.cnt  = st_q.cnt + 1'b1;
                end else begin
                    st_d.mode = MODE_IDLE;
                    st_d.cnt  = '0;
                    st_d.bad  = (st_q.cnt != '0);
                    part_wr   = (st_q.cnt == HALF_POS);
                end
            end else if (st_q.armed && carrier) begin
                enter      = 1'b1;
                shift_en   = 1'b1;
                st_d.mode  = MODE_PKT;
                st_d.armed = 1'b0;
                st_d.cnt   = CNT_W'(1);
            end
        end
        if (preamble_seen && (st_q.mode == MODE_IDLE) && !enter) begin
            st_d.armed = 1'b1;
            st_d.bad   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode  <= MODE_IDLE;
            st_q.armed <= 1'b0;
            st_q.cnt   <= '0;
            st_q.bad   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.mode == MODE_PKT);
    assign cnt    = st_q.cnt;
    assign bad    = st_q.bad;

endmodule

// File: rtl/rxw_shift.sv
module rxw_shift
    import rxw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              word_last,
    input  logic              part_wr,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic              par,
    output logic              wr
);

    localparam int PAD_W = WORD_W - BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] word;
        logic              par;
        logic              wr;
    } shift_t;

    shift_t st_d, st_q;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        shifted = {st_q.sh[WORD_W-2:0], bit_in};
        if (shift_en) begin
            st_d.sh = shifted;
        end
        if (word_last) begin
            st_d.word = shifted;
            st_d.wr   = 1'b1;
        end else if (part_wr) begin
            st_d.word = {st_q.sh[BYTE_W-1:0], {PAD_W{1'b0}}};
            st_d.wr   = 1'b1;
        end
        st_d.par = odd_fill(16'(st_d.word));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sh   <= '0;
            st_q.word <= '0;
            st_q.par  <= 1'b1;
            st_q.wr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign par  = st_q.par;
    assign wr   = st_q.wr;

endmodule

// File: rtl/rxw_assembler.sv
module rxw_assembler #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              bit_in,
    input  logic              carrier,
    input  logic              preamble_seen,
    output logic              pkt_active,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [WORD_W-1:0] word_data,
    output logic              word_par,
    output logic              word_wr,
    output logic              bad_align
);

    logic shift_en;
    logic word_last;
    logic part_wr;

    rxw_ctrl #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .bit_tick      (bit_tick),
        .carrier       (carrier),
        .preamble_seen (preamble_seen),
        .active        (pkt_active),
        .cnt           (bit_cnt),
        .bad           (bad_align),
        .shift_en      (shift_en),
        .word_last     (word_last),
        .part_wr       (part_wr)
    );

    rxw_shift #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) shift_i (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .word_last (word_last),
        .part_wr   (part_wr),
        .bit_in    (bit_in),
        .word      (word_data),
        .par       (word_par),
        .wr        (word_wr)
    );

endmodule

// File: rtl/rxw_assembler_chk.sv
module rxw_assembler_chk #(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_tick,
    input logic              carrier,
    input logic              pkt_active,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [WORD_W-1:0] word_data,
    input logic              word_par,
    input logic              word_wr
);

    // R5: write strobe never lasts two cycles
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        word_wr |=> !word_wr);

    // R5: a write only follows a bit strobe
    a_r5_after_tick: assert property (@(posedge clk) disable iff (rst)
        word_wr |-> $past(bit_tick));

    // R6: odd parity over data and parity bit
    a_r6_odd_parity: assert property (@(posedge clk) disable iff (rst)
        word_wr |-> ((^word_data) ^ word_par) == 1'b1);

    // R7: carrier loss on a strobe ends the packet and clears the count
    a_r7_end_clears: assert property (@(posedge clk) disable iff (rst)
        (pkt_active && bit_tick && !carrier) |=> (!pkt_active && bit_cnt == '0));

    // R12: nothing moves without a bit strobe
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> ($stable(bit_cnt) && $stable(pkt_active)));

    // R2: packet mode cannot start without a strobe
    a_r2_no_spurious_entry: assert property (@(posedge clk) disable iff (rst)
        (!pkt_active && !bit_tick) |=> !pkt_active);

endmodule

bind rxw_assembler rxw_assembler_chk #(.WORD_W(WORD_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .carrier    (carrier),
    .pkt_active (pkt_active),
    .bit_cnt    (bit_cnt),
    .word_data  (word_data),
    .word_par   (word_par),
    .word_wr    (word_wr)
);

// File: tb/rxw_assembler_tb_top.sv
module rxw_assembler_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic        bit_in = 1'b0;
    logic        carrier = 1'b0;
    logic        preamble_seen = 1'b0;
    logic        pkt_active;
    logic [3:0]  bit_cnt;
    logic [15:0] word_data;
    logic        word_par;
    logic        word_wr;
    logic        bad_align;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rxw_assembler dut_i (
        .clk           (clk),
        .rst           (rst),
        .bit_tick      (bit_tick),
        .bit_in        (bit_in),
        .carrier       (carrier),
        .preamble_seen (preamble_seen),
        .pkt_active    (pkt_active),
        .bit_cnt       (bit_cnt),
        .word_data     (word_data),
        .word_par      (word_par),
        .word_wr       (word_wr),
        .bad_align     (bad_align)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic b, input logic car);
        @(negedge clk);
        bit_tick = 1'b1;
        bit_in   = b;
        carrier  = car;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic pre_pulse();
        @(negedge clk);
        preamble_seen = 1'b1;
        @(negedge clk);
        preamble_seen = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) tick(w[i], 1'b1);
        check("R5 strobe", word_wr, 1);
        check("R4 word", word_data, w);
        check("R6 parity", word_par, ~^w);
        check("R5 count", bit_cnt, 0);
        @(negedge clk);
        check("R5 one-cycle", word_wr, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mode", pkt_active, 0);
        check("R1 count", bit_cnt, 0);
        check("R1 flag", bad_align, 0);
        check("R1 strobe", word_wr, 0);

        // R2: unarmed strobes with carrier
        for (int i = 0; i < 17; i++) tick(i[0], 1'b1);
        check("R2 not armed", pkt_active, 0);
        check("R2 count", bit_cnt, 0);
        tick(1'b0, 1'b0);

        // sweep end position over all counts
        for (int c = 0; c < 16; c++) begin
            pre_pulse();
            check("R11 cleared by preamble", bad_align, 0);
            w = 16'(c * 16'h1357) ^ 16'(c << 9) ^ 16'hA5C3;
            tick(w[15], 1'b1);
            check("R3 entered", pkt_active, 1);
            check("R3 first bit counted", bit_cnt, 1);
            for (int i = 14; i >= 0; i--) tick(w[i], 1'b1);
            check("R5 strobe", word_wr, 1);
            check("R4 word", word_data, w);
            check("R6 parity", word_par, ~^w);
            @(negedge clk);
            check("R5 one-cycle", word_wr, 0);
            w = ~w ^ 16'(c * 16'h0F1);
            send_word(w);
            // R13: preamble during packet
            pre_pulse();
            check("R13 mode kept", pkt_active, 1);
            // R12: inputs wiggle without strobe
            @(negedge clk); bit_in = 1'b1; carrier = 1'b0;
            @(negedge clk); bit_in = 1'b0;
            check("R12 count held", bit_cnt, 0);
            check("R12 mode held", pkt_active, 1);
            for (int i = 0; i < c; i++) tick(w[i], 1'b1);
            check("R12 count", bit_cnt, c);
            tick(1'b1, 1'b0);
            check("R7 ended", pkt_active, 0);
            check("R7 count", bit_cnt, 0);
            if (c == 0) begin
                check("R8 flag", bad_align, 0);
                check("R8 no write", word_wr, 0);
            end else if (c == 8) begin
                check("R9 flag", bad_align, 1);
                check("R9 write", word_wr, 1);
                check("R9 partial word", word_data, {w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7], 8'h00});
                check("R6 partial parity", word_par, ~^{w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]});
            end else begin
                check("R10 flag", bad_align, 1);
                check("R10 no write", word_wr, 0);
            end
            // R11: flag holds across idle strobes
            repeat (3) tick(1'b1, 1'b1);
            check("R11 flag held", bad_align, (c != 0));
            check("R2 stays idle", pkt_active, 0);
        end

        // R1: reset mid-packet
        pre_pulse();
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 mode after reset", pkt_active, 0);
        check("R1 count after reset", bit_cnt, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule